// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is a two-wire bus slave that makes a byte-wide on-chip array behave like a serial EEPROM. It runs on a fast system clock and oversamples the bus clock and data lines. From the samples it finds Start and Stop conditions and the edges of the bus clock. It answers only to a select byte that carries the fixed type nibble and the three strapped enable pins. It drives the data line through a single open-drain enable, which pulls the line low when set.

After a select with the write flag, the master sends two address bytes, most significant first, and then any number of data bytes. Data bytes go into the array. The address advances inside a page of `PAGE_BYTES` bytes. The Stop that closes a write starts a busy period of `WRITE_CYCLES` clocks. During that period the slave ignores its select byte, so a master can poll it for completion.

A select with the read flag streams bytes out from the address counter, which wraps at the end of the array. A random read is an address write followed by a repeated Start and a read select. A write-protect input blocks data bytes. A supply-good input, while low, holds the slave idle and silent.

Top module: `eep_slave`

## Requirements
- R1: After reset the slave does not drive the data line, its address counter is zero, and it is not busy, so its first valid select byte is acknowledged.
- R2: A select byte is acknowledged only when its bits 7:4 are 1010 and its bits 3:1 equal `ce_i[2:0]`. Bit 0 is the direction (0 = write, 1 = read). Any other select byte gets no acknowledge, and the slave ignores the bus until the next Start.
- R3: The slave pulls the data line low for the 9th bus clock after each byte it accepts. It drives the line only in acknowledge slots and in the bit slots of a read.
- R4: The memory address arrives as two bytes, high byte first. Only the low `ADDR_W` bits are used, and the upper bits of the 16-bit value are ignored.
- R5: Each data byte of a write is stored at the current address. The address then increments in its low log2(`PAGE_BYTES`) bits only, so it wraps to the start of the same page.
- R6: In a read, the slave sends bytes MSB first while the master acknowledges. After each byte the address increments, and it wraps from the last array location to 0.
- R7: A read select that directly follows a Start returns the byte at the address one past the last byte read or written.
- R8: When the master does not acknowledge a read byte, the slave releases the data line and drives nothing until the next Start.
- R9: While `wc_i` is high, the select byte and both address bytes are still acknowledged. Data bytes get no acknowledge, and the array is left unchanged.
- R10: While `pwr_ok_i` is low, the slave acknowledges nothing and releases the data line. If the input drops in the middle of a transfer, that transfer is abandoned.
- R11: A Stop that ends a write in which at least one data byte was accepted starts a busy period of `WRITE_CYCLES` clocks. During that period no select byte is acknowledged. A write in which no data byte was accepted starts no busy period.
- R12: A Start seen at any point, including in the middle of a byte, restarts select decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok_i | input | 1 | Supply-good qualifier; low holds the slave idle |
| ce_i | input | 3 | Strapped enable bits compared with select bits 3:1 |
| wc_i | input | 1 | Write protect; high blocks data bytes |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
Some properties are checked on every cycle. The data-line enable may only be set in acknowledge or read states. It falls in the cycle after a Stop and in the cycle after the supply-good input goes low. A write never moves the address outside its page. No array write and no new busy period can start while a write cycle is running. A Start always returns the decoder to the select state.

The bench scenarios cover what needs a whole transfer to show:
- data values round-tripping through the array;
- page wrap and end-of-array wrap;
- the current-address pointer;
- write-protect rejection with the array left unchanged;
- select matching;
- polling during the busy period;
- transfers abandoned or restarted midway.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_AHI,
    S_AHI_ACK,
    S_ALO,
    S_ALO_ACK,
    S_WDAT,
    S_WDAT_ACK,
    S_RDAT,
    S_RACK
  } eep_state_e;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/eep_wcycle.sv
module eep_wcycle #(
  parameter int CYCLES = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                  remain <= '0;
    else if (start_i)         remain <= CW'(CYCLES);
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign busy_o = (remain != '0);

  // R11: a new write cycle is never requested while one is running
  p_no_restart_r11: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_o);
endmodule

// File: rtl/eep_slave.sv
module eep_slave #(
  parameter int ADDR_W       = 11,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 4000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_ok_i,
  input  logic [2:0] ce_i,
  input  logic       wc_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  import eep_pkg::*;

  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - 8;

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, wc_start, mem_we, sel_ok;
  logic [7:0] byte_nxt, rd_data, shreg, txq;
  logic [2:0] bcnt;
  logic [HI_W-1:0] addr_hi;
  logic [ADDR_W-1:0] addr_q, page_nxt, full_addr;
  logic oe_q, ack_seen, rw_q, mack_q, wr_pend;
  eep_state_e state;

  eep_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eep_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(addr_q), .wdata(byte_nxt),
    .raddr(addr_q), .rdata(rd_data)
  );

  eep_wcycle #(.CYCLES(WRITE_CYCLES)) u_wcyc (
    .clk(clk), .rst(rst), .start_i(wc_start), .busy_o(busy)
  );

  assign byte_nxt  = {shreg[6:0], sda_s};
  assign full_addr = {addr_hi, byte_nxt};
  assign page_nxt  = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
  assign sel_ok    = (byte_nxt[7:4] == DEV_TYPE) && (byte_nxt[3:1] == ce_i) && !busy;
  assign mem_we    = !rst && pwr_ok_i && !start_evt && !stop_evt && scl_rise &&
                     (state == S_WDAT) && (bcnt == 3'd7) && !wc_i;
  assign wc_start  = !rst && pwr_ok_i && stop_evt && wr_pend;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; bcnt <= '0; shreg <= '0; txq <= '0;
      addr_hi <= '0; addr_q <= '0; oe_q <= 1'b0; ack_seen <= 1'b0;
      rw_q <= 1'b0; mack_q <= 1'b0; wr_pend <= 1'b0;
    end else if (!pwr_ok_i) begin
      state <= S_IDLE; oe_q <= 1'b0; ack_seen <= 1'b0; wr_pend <= 1'b0;
    end else if (start_evt) begin
      state <= S_DEV; bcnt <= '0; oe_q <= 1'b0; ack_seen <= 1'b0;
    end else if (stop_evt) begin
      state <= S_IDLE; oe_q <= 1'b0; wr_pend <= 1'b0;
    end else begin
      case (state)
        S_DEV, S_AHI, S_ALO, S_WDAT: begin
          if (scl_rise) begin
            shreg <= byte_nxt;
            bcnt  <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              ack_seen <= 1'b0;
              case (state)
                S_DEV: begin
                  rw_q  <= byte_nxt[0];
                  state <= sel_ok ? S_DEV_ACK : S_IDLE;
                end
                S_AHI: begin
                  addr_hi <= byte_nxt[HI_W-1:0];
                  state   <= S_AHI_ACK;
                end
                S_ALO: begin
                  addr_q <= full_addr;
                  state  <= S_ALO_ACK;
                end
                default: begin
                  if (!wc_i) begin
                    addr_q  <= page_nxt;
                    wr_pend <= 1'b1;
                    state   <= S_WDAT_ACK;
                  end else begin
                    state <= S_IDLE;
                  end
                end
              endcase
            end
          end
        end
        S_DEV_ACK, S_AHI_ACK, S_ALO_ACK, S_WDAT_ACK: begin
          if (scl_fall) begin
            if (!ack_seen) begin
              oe_q     <= 1'b1;
              ack_seen <= 1'b1;
            end else begin
              oe_q     <= 1'b0;
              ack_seen <= 1'b0;
              bcnt     <= '0;
              case (state)
                S_DEV_ACK: begin
                  if (rw_q) begin
                    state <= S_RDAT;
                    txq   <= rd_data;
                    oe_q  <= ~rd_data[7];
                  end else begin
                    state <= S_AHI;
                  end
                end
                S_AHI_ACK: state <= S_ALO;
                default:   state <= S_WDAT;
              endcase
            end
          end
        end
        S_RDAT: begin
          if (scl_fall) begin
            oe_q <= ~txq[6];
            txq  <= {txq[6:0], 1'b0};
          end else if (scl_rise) begin
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              state    <= S_RACK;
              ack_seen <= 1'b0;
              addr_q   <= addr_q + 1'b1;
            end
          end
        end
        S_RACK: begin
          if (scl_fall) begin
            if (!ack_seen) begin
              oe_q     <= 1'b0;
              ack_seen <= 1'b1;
            end else if (mack_q) begin
              state    <= S_RDAT;
              txq      <= rd_data;
              oe_q     <= ~rd_data[7];
              bcnt     <= '0;
              ack_seen <= 1'b0;
            end else begin
              state <= S_IDLE;
              oe_q  <= 1'b0;
            end
          end else if (scl_rise && ack_seen) begin
            mack_q <= ~sda_s;
          end
        end
        default: ;
      endcase
    end
  end

  // R3: the line is only pulled in acknowledge or read slots
  p_oe_in_slot_r3: assert property (@(posedge clk) disable iff (rst)
    sda_oe_o |-> (state inside {S_DEV_ACK, S_AHI_ACK, S_ALO_ACK, S_WDAT_ACK, S_RDAT, S_RACK}));
  // R10: losing supply-good releases the line
  p_release_off_r10: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok_i |=> !sda_oe_o);
  // R8: a Stop always leaves the line released
  p_release_stop_r8: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe_o);
  // R5: a stored byte never moves the address out of its page
  p_page_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])));
  // R11: no array write while the write cycle runs
  p_no_write_busy_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !mem_we);
  // R12: a Start restarts select decoding
  p_start_restarts_r12: assert property (@(posedge clk) disable iff (rst)
    (start_evt && pwr_ok_i) |=> (state == S_DEV));
endmodule

// File: tb/eep_slave_tb_top.sv
module eep_slave_tb_top;
  localparam int Q   = 8;
  localparam int WCY = 1000;
  localparam logic [7:0] SEL_W = 8'hAA;
  localparam logic [7:0] SEL_R = 8'hAB;
  localparam logic [23:0] VEC [0:5] = '{
    24'h0010_3A, 24'h0123_C7, 24'h07F0_01, 24'h0200_FF, 24'h0455_80, 24'h0333_6E
  };

  logic clk = 1'b0, rst = 1'b1, pwr_ok = 1'b1, wc = 1'b0;
  logic [2:0] ce = 3'b101;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int tests = 0, fails = 0;

  assign sda_bus = sda_m & ~sda_oe;
  always #5 clk = ~clk;

  eep_slave #(.ADDR_W(11), .PAGE_BYTES(64), .WRITE_CYCLES(WCY), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .pwr_ok_i(pwr_ok), .ce_i(ce), .wc_i(wc),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe)
  );

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_c();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic stop_c();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask
  task automatic bit_out(input logic b);
    sda_m = b; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic bit_in(output logic b);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); b = sda_bus; wt(Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(x);
    ack = ~x;
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) begin bit_in(x); d[i] = x; end
    bit_out(~mack);
  endtask

  // address phase; returns 1 when all three bytes were acknowledged
  task automatic addr_phase(input logic [15:0] a, output logic ok);
    logic a0, a1, a2;
    start_c(); send_byte(SEL_W, a0); send_byte(a[15:8], a1); send_byte(a[7:0], a2);
    ok = a0 & a1 & a2;
  endtask
  task automatic write_n(input logic [15:0] a, input int n, input logic [31:0] d);
    logic ok, ak;
    addr_phase(a, ok);
    for (int i = 0; i < n; i++) begin send_byte(d[31-8*i -: 8], ak); ok &= ak; end
    stop_c();
    check("R3 write acks", {31'd0, ok}, 32'd1);
  endtask
  task automatic wait_ready();
    logic ak;
    for (int i = 0; i < 20; i++) begin
      start_c(); send_byte(SEL_W, ak); stop_c();
      if (ak) break;
      wt(200);
    end
  endtask
  task automatic read_open(input logic [15:0] a, output logic ok);
    logic ak;
    addr_phase(a, ok);
    start_c(); send_byte(SEL_R, ak); ok &= ak;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic ok, ak;
    logic [7:0] d;
    wt(5); rst = 1'b0; wt(5);
    // R1: reset state
    check("R1 line released after reset", {31'd0, sda_oe}, 32'd0);
    start_c(); send_byte(SEL_W, ak); stop_c();
    check("R1 first select acked (not busy)", {31'd0, ak}, 32'd1);

    // vector table: byte write, wait, random read back (R4, R5, R6)
    for (int i = 0; i < 6; i++) begin
      write_n(VEC[i][23:8], 1, {VEC[i][7:0], 24'd0});
      wait_ready();
      read_open(VEC[i][23:8], ok);
      recv_byte(1'b0, d); stop_c();
      check("R4 table select/address acks", {31'd0, ok}, 32'd1);
      check("R4 table readback", {24'd0, d}, {24'd0, VEC[i][7:0]});
    end

    // R11: busy after a write, polled until done
    write_n(16'h0100, 1, 32'h7700_0000);
    start_c(); send_byte(SEL_W, ak); stop_c();
    check("R11 select nacked during write cycle", {31'd0, ak}, 32'd0);
    wt(WCY + 200);
    start_c(); send_byte(SEL_W, ak); stop_c();
    check("R11 select acked after write cycle", {31'd0, ak}, 32'd1);

    // R5: page wrap, 0x0FE,0x0FF then back to 0x0C0
    write_n(16'h00FE, 3, 32'hD0D1D200); wait_ready();
    read_open(16'h00C0, ok); recv_byte(1'b0, d); stop_c();
    check("R5 third byte wrapped to page start", {24'd0, d}, 32'hD2);
    read_open(16'h0100, ok); recv_byte(1'b0, d); stop_c();
    check("R5 next page untouched", {24'd0, d}, 32'h77);

    // R4: upper address bits ignored (0x8805 -> 0x005)
    write_n(16'h8805, 1, 32'h5E00_0000); wait_ready();
    read_open(16'h0005, ok); recv_byte(1'b0, d); stop_c();
    check("R4 upper address bits ignored", {24'd0, d}, 32'h5E);

    // R6, R7, R8: sequential read across end of array, then current address
    write_n(16'h07FE, 2, 32'h11A5_0000); wait_ready();
    write_n(16'h0000, 2, 32'h3C4D_0000); wait_ready();
    read_open(16'h07FE, ok);
    recv_byte(1'b1, d); check("R6 seq byte 0x7FE", {24'd0, d}, 32'h11);
    recv_byte(1'b1, d); check("R6 seq byte 0x7FF", {24'd0, d}, 32'hA5);
    recv_byte(1'b0, d); check("R6 wrapped to 0x000", {24'd0, d}, 32'h3C);
    check("R8 line released after NoAck", {31'd0, sda_oe}, 32'd0);
    wt(3*Q);
    check("R8 line still released before Stop", {31'd0, sda_oe}, 32'd0);
    stop_c();
    start_c(); send_byte(SEL_R, ak); recv_byte(1'b0, d); stop_c();
    check("R7 current address read", {24'd0, d}, 32'h4D);

    // R2: select mismatches
    start_c(); send_byte(8'hBA, ak); stop_c();
    check("R2 wrong type code nacked", {31'd0, ak}, 32'd0);
    start_c(); send_byte(8'hA8, ak); stop_c();
    check("R2 wrong enable bits nacked", {31'd0, ak}, 32'd0);

    // R9: write protect
    wc = 1'b1;
    addr_phase(16'h0010, ok); send_byte(8'h99, ak); stop_c();
    check("R9 select/address acked while protected", {31'd0, ok}, 32'd1);
    check("R9 data byte nacked while protected", {31'd0, ak}, 32'd0);
    wc = 1'b0;
    start_c(); send_byte(SEL_W, ak); stop_c();
    check("R11 no write cycle after rejected data", {31'd0, ak}, 32'd1);
    read_open(16'h0010, ok); recv_byte(1'b0, d); stop_c();
    check("R9 array unchanged", {24'd0, d}, 32'h3A);

    // R10: supply-good low
    pwr_ok = 1'b0; wt(4);
    check("R10 line released while supply low", {31'd0, sda_oe}, 32'd0);
    start_c(); send_byte(SEL_W, ak); stop_c();
    check("R10 no ack while supply low", {31'd0, ak}, 32'd0);
    pwr_ok = 1'b1; wt(4);
    start_c(); send_byte(SEL_W, ak); send_byte(8'h00, ok);
    pwr_ok = 1'b0; wt(4); pwr_ok = 1'b1; wt(4);
    send_byte(8'h10, ak); stop_c();
    check("R10 abandoned transfer gives no ack", {31'd0, ak}, 32'd0);

    // R12: repeated Start in the middle of the address
    start_c(); send_byte(SEL_W, ak); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    read_open(16'h0123, ok); recv_byte(1'b0, d); stop_c();
    check("R12 restart acks", {31'd0, ok}, 32'd1);
    check("R12 restart read data", {24'd0, d}, 32'hC7);

    summary();
  end
endmodule